// File: doc/BRIEF.md
# Decode-Inhibit Arbiter for an Internal Memory Expansion

This block decides, combinationally, which side owns each bus cycle on a small 8-bit-bus computer: the on-board decoder chip, a memory expansion fitted inside the machine, or a card on the external expansion connector. The on-board decoder has an inhibit input. Holding that input high makes the decoder treat the cycle as idle, so hardware outside the decoder can answer at any address, including addresses the motherboard normally decodes itself.

The block reads the two most significant CPU address lines and the inhibit level that arrives from the external connector. From these it drives the inhibit level seen by the on-board decoder and a select for the internal expansion memory. The internal expansion claims the windows that its configuration enables. When an external card raises inhibit, the internal expansion gives way for that cycle, and the inhibit still reaches the on-board decoder.

The outputs use only the address lines, the external inhibit and a test enable. No strobe qualifies them and nothing is registered, so the outputs are settled before the data strobe falls.

Top module: `ovr_decode_override`

## Requirements
- R1: With `int_exp_en`=1 and `ext_inhibit`=0, when `cpu_a_hi` is 01 or 10 (the RAM window, where A19 XOR A18 is 1), both `int_mem_sel` and `dec_inhibit` are 1.
- R2: With `ext_inhibit`=0, when `cpu_a_hi` is 00 (the on-board area), both `dec_inhibit` and `int_mem_sel` are 0, so the motherboard decodes the cycle.
- R3: With the default configuration (the I/O window is not claimed) and `ext_inhibit`=0, when `cpu_a_hi` is 11 (the I/O window, where A19 and A18 are both 1), both `dec_inhibit` and `int_mem_sel` are 0.
- R4: Whenever `ext_inhibit` is 1, `dec_inhibit` is 1, whatever the address and enable.
- R5: Whenever `ext_inhibit` is 1, `int_mem_sel` is 0, so the external card takes precedence.
- R6: When `int_exp_en` is 0, `int_mem_sel` is 0 and `dec_inhibit` equals `ext_inhibit` for every address.
- R7: The outputs follow a change of address, `ext_inhibit` or `int_exp_en` without any clock edge. The block has no strobe input and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_a_hi | input | 2 | CPU address bits A19 (bit 1) and A18 (bit 0) |
| ext_inhibit | input | 1 | Inhibit level arriving from the external expansion connector, active high |
| int_exp_en | input | 1 | Enables the internal expansion's claims; 0 switches the expansion off |
| dec_inhibit | output | 1 | Merged inhibit presented to the on-board decoder, active high |
| int_mem_sel | output | 1 | Select for the internal expansion memory, active high |

## Verification
The bench drives every combination of the two address bits, the external inhibit and the enable. A design that decodes the RAM window as a single address-bit test would claim either the on-board area or the I/O window, and would also miss one half of the RAM window. A merge that lets the internal claim win against an external card would raise `int_mem_sel` together with `ext_inhibit`, and both memories would drive the bus. If the external inhibit were dropped from the merge, the on-board decoder would answer at addresses that a card has taken over. The bench also changes the inputs between clock edges and checks that the outputs follow at once, which catches a design that registers or latches its outputs.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

   // Number of high address lines the arbiter inspects (A19..A18).
   localparam int unsigned HI_BITS = 2;

   // Coarse address regions derived from the two top address lines.
   typedef enum logic [1:0] {
      REG_BASE = 2'd0,   // on-board ROM, I/O and RAM
      REG_RAM  = 2'd1,   // memory expansion window
      REG_IO   = 2'd2    // peripheral expansion window
   } region_e;

   // Flags for which expansion windows the current address hits.
   typedef struct packed {
      logic base;
      logic ram;
      logic io;
   } window_t;

endpackage

// File: rtl/ovr_region_decode.sv
module ovr_region_decode
   import ovr_pkg::*;
#(
   parameter int unsigned A_BITS = HI_BITS
) (
   input  logic [A_BITS-1:0] a_hi,
   output window_t           win,
   output region_e           region
);

   localparam int unsigned TOP = A_BITS - 1;

   if (A_BITS != 2) begin : g_bad_width
      $error("ovr_region_decode: exactly two address lines are decoded");
   end

   logic a19, a18;
   assign a19 = a_hi[TOP];
   assign a18 = a_hi[TOP-1];

   // RAM window: one line high, the other low.
   assign win.ram  = a19 ^ a18;
   // I/O window: both lines high.
   assign win.io   = a19 & a18;
   // On-board area: both lines low.
   assign win.base = ~(a19 | a18);

   always_comb begin
      region = REG_BASE;
      if (win.ram)     region = REG_RAM;
      else if (win.io) region = REG_IO;
   end

   // R1: exactly one window matches any address
   always_comb begin
      window_onehot_chk: assert ($onehot({win.base, win.ram, win.io}));
   end

endmodule

// File: rtl/ovr_claim.sv
module ovr_claim
   import ovr_pkg::*;
#(
   parameter bit CLAIM_RAM = 1'b1,
   parameter bit CLAIM_IO  = 1'b0
) (
   input  window_t win,
   input  logic    enable,
   output logic    claim
);

   logic ram_part, io_part;

   if (CLAIM_RAM) begin : g_ram_on
      assign ram_part = win.ram;
   end else begin : g_ram_off
      assign ram_part = 1'b0;
   end

   if (CLAIM_IO) begin : g_io_on
      assign io_part = win.io;
   end else begin : g_io_off
      assign io_part = 1'b0;
   end

   assign claim = enable & (ram_part | io_part);

   // R6: a disabled expansion never claims
   always_comb begin
      if (!enable) en_off_chk: assert (!claim);
   end

   // R2: the on-board area is never claimed
   always_comb begin
      if (win.base) base_free_chk: assert (!claim);
   end

endmodule

// File: rtl/ovr_merge.sv
module ovr_merge (
   input  logic int_claim,
   input  logic ext_inh,
   output logic inh_out,
   output logic int_sel
);

   // External claims both inhibit the decoder and push out the internal memory.
   assign int_sel = int_claim & ~ext_inh;
   assign inh_out = int_claim | ext_inh;

   // R4: an external inhibit always reaches the decoder
   always_comb begin
      if (ext_inh) ext_pass_chk: assert (inh_out);
   end

   // R5: the external card wins over the internal memory
   always_comb begin
      if (ext_inh) ext_wins_chk: assert (!int_sel);
   end

   // R1: a selected internal memory always hides the decoder
   always_comb begin
      if (int_sel) sel_hides_chk: assert (inh_out);
   end

endmodule

// File: rtl/ovr_decode_override.sv
module ovr_decode_override
   import ovr_pkg::*;
#(
   parameter bit CLAIM_RAM = 1'b1,
   parameter bit CLAIM_IO  = 1'b0
) (
   input  logic [HI_BITS-1:0] cpu_a_hi,
   input  logic               ext_inhibit,
   input  logic               int_exp_en,
   output logic               dec_inhibit,
   output logic               int_mem_sel
);

   window_t win;
   region_e region;
   logic    claim;

   ovr_region_decode #(.A_BITS(HI_BITS)) u_region (
      .a_hi   (cpu_a_hi),
      .win    (win),
      .region (region)
   );

   ovr_claim #(.CLAIM_RAM(CLAIM_RAM), .CLAIM_IO(CLAIM_IO)) u_claim (
      .win    (win),
      .enable (int_exp_en),
      .claim  (claim)
   );

   ovr_merge u_merge (
      .int_claim (claim),
      .ext_inh   (ext_inhibit),
      .inh_out   (dec_inhibit),
      .int_sel   (int_mem_sel)
   );

   // R3: an unclaimed I/O window leaves the decoder alone unless a card asks
   always_comb begin
      if (!CLAIM_IO && region == REG_IO && !ext_inhibit) io_free_chk: assert (!dec_inhibit);
   end

endmodule

// File: tb/ovr_decode_override_test.sv
module ovr_decode_override_test;

   logic       clk = 1'b0;
   logic [1:0] a_hi = 2'b00;
   logic       ext = 1'b0;
   logic       en = 1'b0;
   logic       inh, sel;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   ovr_decode_override uut (
      .cpu_a_hi    (a_hi),
      .ext_inhibit (ext),
      .int_exp_en  (en),
      .dec_inhibit (inh),
      .int_mem_sel (sel)
   );

   // Each entry is {a19, a18, ext, en, expected inhibit, expected select}.
   localparam logic [5:0] VEC [16] = '{
      6'b000000, 6'b000100, 6'b001010, 6'b001110,
      6'b010000, 6'b010111, 6'b011010, 6'b011110,
      6'b100000, 6'b100111, 6'b101010, 6'b101110,
      6'b110000, 6'b110100, 6'b111010, 6'b111110
   };

   task automatic check(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s a=%b ext=%b en=%b got=%b exp=%b", tag, a_hi, ext, en, got, exp);
      end
   endtask

   initial begin
      #200000ns;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R2: idle inputs at start-up leave the decoder in charge
      #1;
      check("R2 startup inhibit", inh, 1'b0);
      check("R2 startup select", sel, 1'b0);

      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         {a_hi, ext, en} = VEC[i][5:2];
         #1;
         if (ext) begin
            check("R4 inhibit", inh, VEC[i][1]);
            check("R5 select", sel, VEC[i][0]);
         end else if (!en) begin
            check("R6 inhibit", inh, VEC[i][1]);
            check("R6 select", sel, VEC[i][0]);
         end else if (a_hi[1] ^ a_hi[0]) begin
            check("R1 inhibit", inh, VEC[i][1]);
            check("R1 select", sel, VEC[i][0]);
         end else if (a_hi == 2'b00) begin
            check("R2 inhibit", inh, VEC[i][1]);
            check("R2 select", sel, VEC[i][0]);
         end else begin
            check("R3 inhibit", inh, VEC[i][1]);
            check("R3 select", sel, VEC[i][0]);
         end
      end

      // R7: outputs follow input changes between clock edges
      @(posedge clk);
      #1;
      a_hi = 2'b01; ext = 1'b0; en = 1'b1;
      #1;
      check("R7 window entry select", sel, 1'b1);
      a_hi = 2'b11;
      #1;
      check("R7 window exit select", sel, 1'b0);
      check("R7 window exit inhibit", inh, 1'b0);
      a_hi = 2'b10;
      #1;
      check("R7 second half select", sel, 1'b1);
      ext = 1'b1;
      #1;
      check("R7 R5 card grab select", sel, 1'b0);
      check("R7 R4 card grab inhibit", inh, 1'b1);
      ext = 1'b0;
      #1;
      check("R7 card release select", sel, 1'b1);
      en = 1'b0;
      #1;
      check("R7 R6 disable select", sel, 1'b0);
      check("R7 R6 disable inhibit", inh, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule